// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Capture

This block is a general-purpose pin controller for a pin count that is a multiple of 32 (64 by default, 96 as the other intended size). Software reaches it through a word-addressed register port: one write strobe, one read strobe, an address, and 32-bit write and read data. Each 32-pin group owns one word in each of seven feature banks. The banks are laid out feature by feature, and within a feature word by word. The word address is `feature * (NUM_PINS/32) + (pin / 32)`, and bit `pin % 32` of that word belongs to the pin.

Pin inputs pass through a two-stage synchroniser. A third register holds the previous synchronised value, and comparing the two finds rising and falling edges. Each pin can be armed for rising edges, falling edges, or both. An armed edge sets a sticky status bit, which software clears by writing a one to it. The OR of every status bit drives a single interrupt line. Outputs come from a latch that is changed only through separate write-one-to-set and write-one-to-clear words. The direction bank drives the output enables.

The block has no state machine. Reads are registered: `reg_rdata` updates on the clock edge that samples `reg_rd` and holds its value otherwise.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset, every readable word returns 0, `pin_oe` and `pin_out` are all low, and `irq` is low.
- R2: The word address is `feature * NW + word`, with NW = NUM_PINS/32 and bit `pin % 32` serving the pin. The features are: 0 level, 1 direction, 2 output set, 3 output clear, 4 rising arm, 5 falling arm, 6 edge status. An address at or above `7 * NW` reads as 0.
- R3: The level word returns the synchronised pin inputs, whatever the pin direction. A pin change driven before clock edge k appears in `reg_rdata` only for reads sampled at edge k+2 or later.
- R4: Writing a direction word stores it. A 1 bit sets the matching `pin_oe` bit from the next cycle on, and the stored word reads back unchanged.
- R5: A 1 written to an output-set (or output-clear) bit drives that `pin_out` bit high (or low) from the next cycle on. Bits written as 0 leave the latch unchanged. Both words read as 0.
- R6: A status bit is set two cycles after a rising input change on a pin whose rising-arm bit is 1. It is never set by an edge on a pin with no matching arm bit.
- R7: A falling input change sets status when the falling-arm bit is 1. With both arm bits set, either edge sets status.
- R8: Writing 1 to a status bit clears it. Bits written as 0 keep their value. Without a clear write, a set status bit never drops.
- R9: When a clear write and a new armed edge reach the same status bit on the same clock edge, the bit ends up set.
- R10: `irq` is high exactly while at least one status bit in any word is set, and it stays high until every set bit has been cleared.
- R11: `reg_rdata` changes only on a clock edge where `reg_rd` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address (4 at the default) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| pin_in | input | NUM_PINS | Pad input levels (asynchronous) |
| pin_out | output | NUM_PINS | Output latch |
| pin_oe | output | NUM_PINS | Output enables (1 = drive) |
| irq | output | 1 | OR of all edge status bits |

## Verification
The properties assume that `reg_wr` and `reg_rd` are never high together. They also assume that register inputs and pad inputs change only away from the rising clock edge, so the synchroniser sees clean levels in simulation. The stimulus drives every input on the falling edge and issues one access per cycle. It holds each pin pattern for several cycles before it reads status, so every expected edge has crossed both synchroniser stages. The same-cycle case is timed by counting those stages, which places the clear write on the exact edge where the status bit would be set.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int WORD_W   = 32;
    localparam int NUM_FEAT = 7;

    typedef enum logic [2:0] {
        FEAT_LEVEL = 3'd0,
        FEAT_DIR   = 3'd1,
        FEAT_SET   = 3'd2,
        FEAT_CLR   = 3'd3,
        FEAT_RISE  = 3'd4,
        FEAT_FALL  = 3'd5,
        FEAT_STAT  = 3'd6
    } feat_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign level_o = sync_q;
    assign rise_o  = sync_q & ~prev_q;
    assign fall_o  = ~sync_q & prev_q;
endmodule

// File: rtl/gpio_edge_word.sv
module gpio_edge_word
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_rise,
    input  logic              we_fall,
    input  logic              we_stat,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rise_pulse,
    input  logic [WORD_W-1:0] fall_pulse,
    output logic [WORD_W-1:0] rise_en,
    output logic [WORD_W-1:0] fall_en,
    output logic [WORD_W-1:0] status
);
    logic [WORD_W-1:0] hit;
    logic [WORD_W-1:0] clr_mask;
    logic [WORD_W-1:0] status_d;

    always_comb begin
        hit      = (rise_pulse & rise_en) | (fall_pulse & fall_en);
        clr_mask = we_stat ? wdata : '0;
        status_d = (status & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            status  <= '0;
        end else begin
            if (we_rise) rise_en <= wdata;
            if (we_fall) fall_en <= wdata;
            status <= status_d;
        end
    end
endmodule

// File: rtl/gpio_out_word.sv
module gpio_out_word
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_dir,
    input  logic              we_set,
    input  logic              we_clr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] dir,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] dout_d;

    always_comb begin
        dout_d = dout;
        if (we_set) dout_d = dout_d | wdata;
        if (we_clr) dout_d = dout_d & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir  <= '0;
            dout <= '0;
        end else begin
            if (we_dir) dir <= wdata;
            dout <= dout_d;
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = $clog2(NUM_FEAT * (NUM_PINS / 32))
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq
);
    localparam int NW = NUM_PINS / WORD_W;

    logic [NUM_PINS-1:0] level_vec;
    logic [NUM_PINS-1:0] rise_pls;
    logic [NUM_PINS-1:0] fall_pls;
    logic [NUM_PINS-1:0] dir_vec;
    logic [NUM_PINS-1:0] rise_vec;
    logic [NUM_PINS-1:0] fall_vec;
    logic [NUM_PINS-1:0] status_vec;

    logic [WORD_W-1:0] feat_word [NUM_FEAT][NW];
    logic [WORD_W-1:0] rd_mux;
    logic [WORD_W-1:0] rdata_q;

    gpio_in_sync #(.W(NUM_PINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pad_i   (pin_in),
        .level_o (level_vec),
        .rise_o  (rise_pls),
        .fall_o  (fall_pls)
    );

    for (genvar w = 0; w < NW; w++) begin : g_word
        localparam int LO = w * WORD_W;
        logic sel_dir, sel_set, sel_clr, sel_rise, sel_fall, sel_stat;

        assign sel_dir  = reg_wr && (reg_addr == ADDR_W'(int'(FEAT_DIR)  * NW + w));
        assign sel_set  = reg_wr && (reg_addr == ADDR_W'(int'(FEAT_SET)  * NW + w));
        assign sel_clr  = reg_wr && (reg_addr == ADDR_W'(int'(FEAT_CLR)  * NW + w));
        assign sel_rise = reg_wr && (reg_addr == ADDR_W'(int'(FEAT_RISE) * NW + w));
        assign sel_fall = reg_wr && (reg_addr == ADDR_W'(int'(FEAT_FALL) * NW + w));
        assign sel_stat = reg_wr && (reg_addr == ADDR_W'(int'(FEAT_STAT) * NW + w));

        gpio_out_word u_out (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_dir (sel_dir),
            .we_set (sel_set),
            .we_clr (sel_clr),
            .wdata  (reg_wdata),
            .dir    (dir_vec[LO +: WORD_W]),
            .dout   (pin_out[LO +: WORD_W])
        );

        gpio_edge_word u_edge (
            .clk        (clk),
            .rst_n      (rst_n),
            .we_rise    (sel_rise),
            .we_fall    (sel_fall),
            .we_stat    (sel_stat),
            .wdata      (reg_wdata),
            .rise_pulse (rise_pls[LO +: WORD_W]),
            .fall_pulse (fall_pls[LO +: WORD_W]),
            .rise_en    (rise_vec[LO +: WORD_W]),
            .fall_en    (fall_vec[LO +: WORD_W]),
            .status     (status_vec[LO +: WORD_W])
        );

        assign feat_word[FEAT_LEVEL][w] = level_vec[LO +: WORD_W];
        assign feat_word[FEAT_DIR][w]   = dir_vec[LO +: WORD_W];
        assign feat_word[FEAT_SET][w]   = '0;
        assign feat_word[FEAT_CLR][w]   = '0;
        assign feat_word[FEAT_RISE][w]  = rise_vec[LO +: WORD_W];
        assign feat_word[FEAT_FALL][w]  = fall_vec[LO +: WORD_W];
        assign feat_word[FEAT_STAT][w]  = status_vec[LO +: WORD_W];
    end

    always_comb begin
        rd_mux = '0;
        for (int f = 0; f < NUM_FEAT; f++) begin
            for (int w = 0; w < NW; w++) begin
                if (reg_addr == ADDR_W'(f * NW + w)) rd_mux = feat_word[f][w];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (reg_rd) rdata_q <= rd_mux;
    end

    assign reg_rdata = rdata_q;
    assign pin_oe    = dir_vec;
    assign irq       = |status_vec;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter int NUM_PINS = 64,
    parameter int ADDR_W   = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                reg_wr,
    input logic [ADDR_W-1:0]   reg_addr,
    input logic [31:0]         reg_wdata,
    input logic [NUM_PINS-1:0] pin_out,
    input logic [NUM_PINS-1:0] pin_oe,
    input logic                irq,
    input logic [NUM_PINS-1:0] status_vec,
    input logic [NUM_PINS-1:0] rise_vec,
    input logic [NUM_PINS-1:0] fall_vec
);
    localparam int NW = NUM_PINS / 32;
    localparam logic [ADDR_W-1:0] A_DIR0  = ADDR_W'(1 * NW);
    localparam logic [ADDR_W-1:0] A_SET0  = ADDR_W'(2 * NW);
    localparam logic [ADDR_W-1:0] A_CLR0  = ADDR_W'(3 * NW);
    localparam logic [ADDR_W-1:0] A_STAT0 = ADDR_W'(6 * NW);

    // R1
    reset_clean_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (pin_oe == '0 && pin_out == '0 && !irq));

    // R4
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_DIR0) |=> (pin_oe[31:0] == $past(reg_wdata)));

    // R5
    set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_SET0) |=> ((pin_out[31:0] & $past(reg_wdata)) == $past(reg_wdata)));

    // R5
    clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_CLR0) |=> ((pin_out[31:0] & $past(reg_wdata)) == '0));

    // R8
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr == A_STAT0)
        |=> ((status_vec[31:0] & $past(status_vec[31:0])) == $past(status_vec[31:0])));

    // R6
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_vec == '0 && fall_vec == '0 && status_vec == '0) |=> (status_vec == '0));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !reg_wr) |=> irq);
endmodule

bind gpio_bank_ctrl gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .irq        (irq),
    .status_vec (status_vec),
    .rise_vec   (rise_vec),
    .fall_vec   (fall_vec)
);

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    localparam int NP = 64;
    localparam int NW = NP / 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    gpio_bank_ctrl #(.NUM_PINS(NP)) dut (
        .clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
        .reg_rdata, .pin_in, .pin_out, .pin_oe, .irq
    );

    function automatic logic [AW-1:0] adr(int feat, int word);
        return AW'(feat * NW + word);
    endfunction

    function automatic void expect_rd(logic [31:0] e, string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endfunction

    task automatic chk(logic [NP-1:0] act, logic [NP-1:0] e, string t);
        n_chk++;
        if (act !== e) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", t, act, e);
        end
    endtask

    task automatic do_write(int a, logic [31:0] d);
        @(negedge clk);
        reg_rd = 1'b0; reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    endtask

    task automatic do_read(int a, logic [31:0] e, string t);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b1; reg_addr = AW'(a);
        expect_rd(e, t);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            reg_wr = 1'b0; reg_rd = 1'b0;
        end
    endtask

    // monitor: pops the scoreboard after every sampled read
    initial begin
        forever begin
            @(posedge clk);
            if (reg_rd) begin
                @(negedge clk);
                if (exp_q.size() > 0) begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    n_chk++;
                    if (reg_rdata !== e) begin
                        n_err++;
                        $display("FAIL %s actual=%h expected=%h", t, reg_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        #2000000;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pin_oe, '0, "R1 pin_oe");
        chk(pin_out, '0, "R1 pin_out");
        chk(NP'(irq), '0, "R1 irq");
        for (int a = 0; a < 7 * NW; a++) do_read(a, 32'h0, "R1 reset word");

        // R3 level read and synchroniser latency
        @(negedge clk);
        reg_rd = 1'b0;
        pin_in = 64'hA5A5_0F0F_1234_8001;
        idle(4);
        do_read(adr(0, 0), 32'h1234_8001, "R3 level w0");
        do_read(adr(0, 1), 32'hA5A5_0F0F, "R3 level w1 R2");
        @(negedge clk);
        pin_in[0] = 1'b0;
        reg_rd = 1'b1; reg_addr = adr(0, 0);
        expect_rd(32'h1234_8001, "R3 latency edge k");
        do_read(adr(0, 0), 32'h1234_8001, "R3 latency edge k+1");
        do_read(adr(0, 0), 32'h1234_8000, "R3 latency edge k+2");
        idle(1);
        pin_in = '0;
        idle(4);

        // R4 direction
        do_write(adr(1, 0), 32'h0000_FFFF);
        do_write(adr(1, 1), 32'hF000_0000);
        idle(1);
        chk(pin_oe, 64'hF000_0000_0000_FFFF, "R4 pin_oe");
        do_read(adr(1, 0), 32'h0000_FFFF, "R4 dir readback");
        do_read(adr(0, 0), 32'h0, "R3 level ignores direction");

        // R5 output latch
        do_write(adr(2, 0), 32'h0000_00FF);
        do_write(adr(2, 1), 32'h8000_0000);
        idle(1);
        chk(pin_out, 64'h8000_0000_0000_00FF, "R5 set");
        do_write(adr(2, 0), 32'h0);
        do_write(adr(3, 0), 32'h0000_000F);
        idle(1);
        chk(pin_out, 64'h8000_0000_0000_00F0, "R5 clear, zero bits ignored");
        do_read(adr(2, 0), 32'h0, "R5 set reads 0");
        do_read(adr(3, 1), 32'h0, "R5 clear reads 0");

        // R6 R7 edge arming
        do_write(adr(4, 0), 32'h3);
        do_write(adr(5, 0), 32'h6);
        do_read(adr(4, 0), 32'h3, "R2 rise arm readback");
        do_read(adr(5, 0), 32'h6, "R2 fall arm readback");
        idle(1);
        pin_in[3:0] = 4'hD;            // pins 0,2,3 rise
        idle(4);
        chk(NP'(irq), 64'h1, "R10 irq set");
        do_read(adr(6, 0), 32'h1, "R6 rise armed only pin0");
        do_write(adr(6, 0), 32'h1);
        idle(1);
        chk(NP'(irq), 64'h0, "R10 irq cleared");
        do_read(adr(6, 0), 32'h0, "R8 w1c");
        idle(1);
        pin_in[3:0] = 4'hB;            // pin2 falls, pin1 rises
        idle(4);
        do_read(adr(6, 0), 32'h6, "R7 fall pin2 and rise pin1");
        do_write(adr(6, 0), 32'h2);
        do_read(adr(6, 0), 32'h4, "R8 zero bits keep value");
        idle(1);
        pin_in[3:0] = 4'h9;            // pin1 falls
        idle(4);
        do_read(adr(6, 0), 32'h6, "R7 both edges pin1");
        do_write(adr(6, 0), 32'h6);
        idle(1);
        chk(NP'(irq), 64'h0, "R10 all cleared");

        // R9 clear and edge on the same clock edge
        pin_in[1] = 1'b1;
        @(negedge clk);
        do_write(adr(6, 0), 32'h2);
        idle(2);
        do_read(adr(6, 0), 32'h2, "R9 edge wins over clear");
        do_write(adr(6, 0), 32'h2);
        do_read(adr(6, 0), 32'h0, "R9 later clear works");

        // R2 upper word and unmapped address
        do_write(adr(4, 1), 32'h8000_0000);
        idle(1);
        pin_in[63] = 1'b1;
        idle(4);
        chk(NP'(irq), 64'h1, "R10 irq from word1");
        do_read(adr(6, 1), 32'h8000_0000, "R2 status word1 bit31");
        do_read(adr(6, 0), 32'h0, "R2 status word0 untouched");
        do_read(14, 32'h0, "R2 unmapped reads 0");

        // R11 read data holds between reads
        do_read(adr(0, 1), 32'h8000_0000, "R11 level read");
        idle(1);
        held = 32'h8000_0000;
        pin_in[62] = 1'b1;
        idle(5);
        chk(NP'(reg_rdata), NP'(held), "R11 rdata holds");

        idle(3);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule